// File: doc/BRIEF.md
# Serial Converter Control and Channel Sequencer

This block is the digital side of a four-channel, 12-bit successive-approximation converter with a serial port. A host frames each transaction with an active-low chip-select and a serial clock. On the chip-select falling edge the block takes the current value of the selected channel's sample port as that frame's conversion result. It then shifts out a 16-bit word on `sdo` while it shifts in a 16-bit control word on `sdi`. The parallel sample ports stand in for the analog front end.

The control word holds the configuration: a fixed channel, or a set of channels that a sequencer visits on successive frames, plus the output coding, an input-range flag and a power mode. The range flag is only stored and reported. Full shutdown turns off conversions but still accepts writes. All serial inputs are resynchronised to the system clock `clk`, so the serial clock must be a few times slower than `clk`.

Top module: `sar_seq_ctl`

## Requirements
- R1: After reset the block uses channel 0 with straight binary coding and the sequencer off. `range_x2` and `sdo` are 0.
- R2: A frame outputs 16 bits, MSB first: the 2-bit channel number, then two zeros, then the 12-bit result. The first bit is valid after the chip-select falls. Each following bit is presented after a serial clock falling edge.
- R3: The result in a frame is the selected channel's sample at the chip-select falling edge of that same frame. A later change to the sample port does not alter that frame.
- R4: The bits on `sdi` are taken on serial clock rising edges, MSB first. On the 16th rising edge the configuration is loaded, and only if frame bit 15 (the write flag) is 1. Frame bits 3..0 are ignored.
- R5: If chip-select rises before the 16th rising edge, the frame is abandoned. The configuration and the sequencer position stay unchanged.
- R6: When frame bit 4 is 1, the output uses two's complement coding, formed by inverting the MSB of the sample. When it is 0, the output is straight binary.
- R7: Frame bit 5 is stored as the range flag and appears on `range_x2`.
- R8: When the sequencer is off (frame bit 14 = 0, or an empty channel set), frame bits 9..8 select the converted channel.
- R9: Frame bit 14 = 1 with a non-empty set in bits 13..10 (bit 10 + n selects channel n) turns the sequencer on. The writing frame sets the position to the lowest selected channel. Each later completed frame moves to the next higher selected channel and wraps from the highest to the lowest.
- R10: A power mode of 11 in frame bits 7..6 is full shutdown. Frames then output all zeros, yet writes are still accepted, so a new mode takes effect in the next frame. Other mode values convert normally.
- R11: `sdo` is 0 while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial control data in |
| samples | input | NUM_CH*DATA_W | Sample port, channel n at bits n*DATA_W upward |
| sdo | output | 1 | Serial result data out |
| range_x2 | output | 1 | Stored input-range flag |

## Verification
The assertions watch every cycle for four things:
- `sdo` stays low while chip-select is idle.
- The channel, coding and power settings change only just after a completed frame.
- A frame without the write flag leaves the settings alone.
- The range flag follows the written bit, and a shutdown conversion starts with a zero bit.

Some behaviour needs whole transactions and only the directed scenarios show it: the exact bit order of the output word, the no-pipeline capture instant, the visiting order and wrap of the sequencer, abort handling, and leaving shutdown.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   localparam int DEF_NUM_CH = 4;
   localparam int DEF_DATA_W = 12;
   localparam int PAD_W      = 2;
   localparam int PWR_W      = 2;
   // write flag, sequencer flag, range flag, coding flag
   localparam int FLAG_BITS  = 4;

   typedef enum logic [PWR_W-1:0] {
      PWR_RUN   = 2'b00,
      PWR_AUTO  = 2'b01,
      PWR_LIGHT = 2'b10,
      PWR_OFF   = 2'b11
   } pwr_e;

endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES > 4) begin : g_bad_stages
      $error("sar_seq_sync: STAGES above 4 is not supported");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
         end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign q = stage_q[STAGES-1];
   end

endmodule

// File: rtl/sar_seq_frame.sv
module sar_seq_frame #(
   parameter int FRAME_W = 16,
   parameter int CTRL_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n_s,
   input  logic               sclk_s,
   input  logic               sdi_s,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               sdo,
   output logic               frame_done,
   output logic [CTRL_W-1:0]  ctrl_word
);

   localparam int CNT_W = $clog2(FRAME_W + 1);

   if (CTRL_W > FRAME_W) begin : g_bad_ctrl
      $error("sar_seq_frame: control field wider than the frame");
   end

   logic               cs_q, sclk_q;
   logic               cs_fall, cs_rise, sclk_rise, sclk_fall;
   logic               active_q;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] tx_sh;
   logic [CTRL_W-1:0]  rx_sh;
   logic               sdo_q, done_q;

   assign cs_fall   =  cs_q & ~cs_n_s;
   assign cs_rise   = ~cs_q &  cs_n_s;
   assign sclk_rise = ~sclk_q &  sclk_s;
   assign sclk_fall =  sclk_q & ~sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         sclk_q   <= 1'b0;
         active_q <= 1'b0;
         bit_cnt  <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         sdo_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         cs_q   <= cs_n_s;
         sclk_q <= sclk_s;
         done_q <= 1'b0;
         if (cs_fall) begin
            // conversion instant: result word is taken here
            active_q <= 1'b1;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            sdo_q    <= tx_word[FRAME_W-1];
            tx_sh    <= tx_word << 1;
         end else if (cs_rise) begin
            active_q <= 1'b0;
            sdo_q    <= 1'b0;
         end else if (active_q) begin
            if (sclk_rise && (bit_cnt < CNT_W'(FRAME_W))) begin
               if (bit_cnt < CNT_W'(CTRL_W)) rx_sh <= {rx_sh[CTRL_W-2:0], sdi_s};
               bit_cnt <= bit_cnt + 1'b1;
               done_q  <= (bit_cnt == CNT_W'(FRAME_W - 1));
            end
            if (sclk_fall && (bit_cnt != '0) && (bit_cnt < CNT_W'(FRAME_W))) begin
               sdo_q <= tx_sh[FRAME_W-1];
               tx_sh <= tx_sh << 1;
            end
         end
      end
   end

   assign sdo        = sdo_q;
   assign frame_done = done_q;
   assign ctrl_word  = rx_sh;

endmodule

// File: rtl/sar_seq_cfg.sv
module sar_seq_cfg
   import sar_seq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 2,
   parameter int CTRL_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic [CTRL_W-1:0] ctrl_word,
   output logic [ADDR_W-1:0] cur_ch,
   output logic              twos,
   output logic              pwr_off,
   output logic              range_x2
);

   // field positions inside the captured control bits
   localparam int F_WR      = CTRL_W - 1;
   localparam int F_SEQ     = CTRL_W - 2;
   localparam int F_MASK_LO = F_SEQ - NUM_CH;
   localparam int F_ADDR_LO = F_MASK_LO - ADDR_W;
   localparam int F_PWR_LO  = F_ADDR_LO - PWR_W;
   localparam int F_RANGE   = F_PWR_LO - 1;
   localparam int F_TWOS    = F_RANGE - 1;

   if (F_TWOS != 0) begin : g_bad_layout
      $error("sar_seq_cfg: control field layout does not fill CTRL_W");
   end

   logic              seq_en_q;
   logic [NUM_CH-1:0] mask_q;
   logic [ADDR_W-1:0] addr_q;
   pwr_e              pwr_q;
   logic              range_q, twos_q;
   logic [ADDR_W-1:0] pos_q;
   logic              seq_act;
   logic [NUM_CH-1:0] new_mask;

   function automatic logic [ADDR_W-1:0] lowest_sel(input logic [NUM_CH-1:0] m);
      logic [ADDR_W-1:0] r;
      r = '0;
      for (int k = NUM_CH - 1; k >= 0; k--) if (m[k]) r = ADDR_W'(k);
      return r;
   endfunction

   function automatic logic [ADDR_W-1:0] next_sel(input logic [ADDR_W-1:0] p,
                                                  input logic [NUM_CH-1:0] m);
      logic [ADDR_W-1:0] r;
      logic              hit;
      r   = p;
      hit = 1'b0;
      for (int k = 1; k <= NUM_CH; k++) begin
         int idx;
         idx = (int'(p) + k) % NUM_CH;
         if (!hit && m[idx]) begin
            r   = ADDR_W'(idx);
            hit = 1'b1;
         end
      end
      return r;
   endfunction

   assign new_mask = ctrl_word[F_MASK_LO +: NUM_CH];
   assign seq_act  = seq_en_q && (|mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_en_q <= 1'b0;
         mask_q   <= '0;
         addr_q   <= '0;
         pwr_q    <= PWR_RUN;
         range_q  <= 1'b0;
         twos_q   <= 1'b0;
         pos_q    <= '0;
      end else if (frame_done) begin
         if (ctrl_word[F_WR]) begin
            seq_en_q <= ctrl_word[F_SEQ];
            mask_q   <= new_mask;
            addr_q   <= ctrl_word[F_ADDR_LO +: ADDR_W];
            pwr_q    <= pwr_e'(ctrl_word[F_PWR_LO +: PWR_W]);
            range_q  <= ctrl_word[F_RANGE];
            twos_q   <= ctrl_word[F_TWOS];
            pos_q    <= lowest_sel(new_mask);
         end else if (seq_act && (pwr_q != PWR_OFF)) begin
            pos_q <= next_sel(pos_q, mask_q);
         end
      end
   end

   assign cur_ch   = seq_act ? pos_q : addr_q;
   assign twos     = twos_q;
   assign pwr_off  = (pwr_q == PWR_OFF);
   assign range_x2 = range_q;

endmodule

// File: rtl/sar_seq_ctl.sv
module sar_seq_ctl
   import sar_seq_pkg::*;
#(
   parameter int NUM_CH      = DEF_NUM_CH,
   parameter int DATA_W      = DEF_DATA_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     sclk,
   input  logic                     sdi,
   input  logic [NUM_CH*DATA_W-1:0] samples,
   output logic                     sdo,
   output logic                     range_x2
);

   localparam int ADDR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int SLOTS   = 1 << ADDR_W;
   localparam int FRAME_W = ADDR_W + PAD_W + DATA_W;
   localparam int CTRL_W  = FLAG_BITS + NUM_CH + ADDR_W + PWR_W;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("sar_seq_ctl: NUM_CH must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("sar_seq_ctl: DATA_W must be at least 2");
   end
   if (CTRL_W > FRAME_W) begin : g_bad_frame
      $error("sar_seq_ctl: control word does not fit in one frame");
   end

   logic                cs_n_s, sclk_s, sdi_s;
   logic                frame_done;
   logic [CTRL_W-1:0]   ctrl_word;
   logic [ADDR_W-1:0]   cur_ch;
   logic                twos, pwr_off;
   logic [DATA_W-1:0]   slot [SLOTS];
   logic [DATA_W-1:0]   raw, coded;
   logic [FRAME_W-1:0]  tx_word;

   sar_seq_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (3),
      .RST_VAL (3'b100)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdi}),
      .q     ({cs_n_s, sclk_s, sdi_s})
   );

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < NUM_CH) begin : g_real
         assign slot[g] = samples[g*DATA_W +: DATA_W];
      end else begin : g_empty
         assign slot[g] = '0;
      end
   end

   assign raw     = slot[cur_ch];
   assign coded   = twos ? {~raw[DATA_W-1], raw[DATA_W-2:0]} : raw;
   assign tx_word = pwr_off ? '0 : {cur_ch, {PAD_W{1'b0}}, coded};

   sar_seq_frame #(
      .FRAME_W (FRAME_W),
      .CTRL_W  (CTRL_W)
   ) frame_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s     (cs_n_s),
      .sclk_s     (sclk_s),
      .sdi_s      (sdi_s),
      .tx_word    (tx_word),
      .sdo        (sdo),
      .frame_done (frame_done),
      .ctrl_word  (ctrl_word)
   );

   sar_seq_cfg #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .CTRL_W (CTRL_W)
   ) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .ctrl_word  (ctrl_word),
      .cur_ch     (cur_ch),
      .twos       (twos),
      .pwr_off    (pwr_off),
      .range_x2   (range_x2)
   );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int CTRL_W = 12,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_s,
   input logic              sdo,
   input logic              frame_done,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic [ADDR_W-1:0] cur_ch,
   input logic              twos,
   input logic              pwr_off,
   input logic              range_x2
);

   // R11: output quiet while the frame select is idle
   p_sdo_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && $past(cs_n_s)) |-> !sdo);

   // R5: channel choice moves only right after a completed frame
   p_ch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_ch) |-> $past(frame_done));

   // R6: coding changes only through a completed write
   p_coding_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(twos) |-> $past(frame_done));

   // R4: a frame without the write flag leaves the settings alone
   p_write_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !ctrl_word[CTRL_W-1]) |=>
         ($stable(twos) && $stable(pwr_off) && $stable(range_x2)));

   // R7: range flag follows the written bit
   p_range_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && ctrl_word[CTRL_W-1]) |=> (range_x2 == $past(ctrl_word[1])));

   // R10: shutdown entered only through a completed frame, and a
   // shutdown conversion begins with a zero bit
   p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwr_off) |-> $past(frame_done));

   p_off_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_off && $fell(cs_n_s)) |=> !sdo);

endmodule

bind sar_seq_ctl sar_seq_chk #(
   .CTRL_W (CTRL_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n_s     (cs_n_s),
   .sdo        (sdo),
   .frame_done (frame_done),
   .ctrl_word  (ctrl_word),
   .cur_ch     (cur_ch),
   .twos       (twos),
   .pwr_off    (pwr_off),
   .range_x2   (range_x2)
);

// File: tb/sar_seq_ctl_tb_top.sv
`timescale 1ns/1ps
module sar_seq_ctl_tb_top;

   localparam int HALF = 8;   // clk cycles per serial clock phase

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic [47:0] samples;
   logic        sdo, range_x2;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 0;

   // poke applied just after the chip-select falls
   bit          poke_en = 0;
   int          poke_ch = 0;
   logic [11:0] poke_val = '0;

   // reference state kept from the requirements
   logic       m_seq = 0, m_off = 0, m_range = 0, m_twos = 0;
   logic [3:0] m_mask = '0;
   logic [1:0] m_addr = '0, m_pos = '0;

   always #2.5 clk = ~clk;

   sar_seq_ctl dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .samples  (samples),
      .sdo      (sdo),
      .range_x2 (range_x2)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [11:0] smp(input logic [1:0] ch);
      return samples[ch*12 +: 12];
   endfunction

   function automatic logic [1:0] ref_lowest(input logic [3:0] m);
      for (int k = 0; k < 4; k++) if (m[k]) return 2'(k);
      return 2'd0;
   endfunction

   function automatic logic [1:0] ref_next(input logic [1:0] p, input logic [3:0] m);
      for (int k = 1; k <= 4; k++) if (m[(int'(p) + k) % 4]) return 2'((int'(p) + k) % 4);
      return p;
   endfunction

   // expected output word of the next frame, from the model state
   function automatic logic [15:0] ref_word();
      logic [1:0]  ch;
      logic [11:0] d;
      if (m_off) return 16'h0000;
      ch = (m_seq && |m_mask) ? m_pos : m_addr;
      d  = smp(ch);
      if (m_twos) d[11] = ~d[11];
      return {ch, 2'b00, d};
   endfunction

   task automatic ref_commit(input logic [15:0] din);
      if (din[15]) begin
         m_seq = din[14]; m_mask = din[13:10]; m_addr = din[9:8];
         m_off = (din[7:6] == 2'b11); m_range = din[5]; m_twos = din[4];
         m_pos = ref_lowest(din[13:10]);
      end else if (m_seq && |m_mask && !m_off) begin
         m_pos = ref_next(m_pos, m_mask);
      end
   endtask

   task automatic run_frame(input logic [15:0] din, input int nrise, output logic [15:0] dout);
      dout = '0;
      sdi  = din[15];
      cs_n = 1'b0;
      wait_clk(HALF);
      if (poke_en) begin
         samples[poke_ch*12 +: 12] = poke_val;
         poke_en = 0;
      end
      for (int i = 0; i < nrise; i++) begin
         dout[15-i] = sdo;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
         if (i < 15) sdi = din[14-i];
         wait_clk(HALF);
      end
      cs_n = 1'b1;
      wait_clk(HALF);
      chk("R11 sdo idle after frame", {15'd0, sdo}, 16'h0000);
   endtask

   // full frame compared against the model
   task automatic frame_ref(input string tag, input logic [15:0] din);
      logic [15:0] exp, got;
      exp = ref_word();
      run_frame(din, 16, got);
      chk(tag, got, exp);
      ref_commit(din);
   endtask

   task automatic t_reset();
      chk("R1 reset sdo", {15'd0, sdo}, 16'h0000);
      chk("R1 reset range_x2", {15'd0, range_x2}, 16'h0000);
      frame_ref("R1 R2 reset config ch0 binary", 16'h0000);
      chk("R2 word layout ch0", ref_word(), {2'b00, 2'b00, 12'hA5C});
   endtask

   task automatic t_manual();
      frame_ref("R4 write frame returns old channel", 16'h8200);
      frame_ref("R8 R2 manual ch2", 16'h0300);
      frame_ref("R4 no write flag keeps ch2", 16'h0000);
      frame_ref("R4 ignored low bits", 16'h000F);
   endtask

   task automatic t_no_pipeline();
      logic [15:0] exp, got;
      exp = ref_word();
      poke_en = 1; poke_ch = 2; poke_val = 12'h555;
      run_frame(16'h0000, 16, got);
      chk("R3 sample held at capture", got, exp);
      ref_commit(16'h0000);
      frame_ref("R3 next frame sees new sample", 16'h0000);
   endtask

   task automatic t_coding();
      frame_ref("R6 write twos on ch1", 16'h8110);
      frame_ref("R6 twos coding 3F1", 16'h0000);
      samples[1*12 +: 12] = 12'hF00;
      frame_ref("R6 twos coding F00", 16'h0000);
   endtask

   task automatic t_range();
      frame_ref("R7 write range", 16'h8130);
      chk("R7 range_x2 set", {15'd0, range_x2}, {15'd0, m_range});
      frame_ref("R7 clear range", 16'h8110);
      chk("R7 range_x2 clear", {15'd0, range_x2}, {15'd0, m_range});
   endtask

   task automatic t_abort();
      logic [15:0] got;
      run_frame(16'h8320, 9, got);
      chk("R5 range untouched by abort", {15'd0, range_x2}, {15'd0, m_range});
      frame_ref("R5 config untouched by abort", 16'h0000);
   endtask

   task automatic t_seq();
      logic [15:0] got;
      frame_ref("R9 write sequence ch1 ch3", 16'hE800);
      frame_ref("R9 seq first ch1", 16'h0000);
      frame_ref("R9 seq then ch3", 16'h0000);
      frame_ref("R9 seq wraps to ch1", 16'h0000);
      run_frame(16'h0000, 6, got);
      frame_ref("R5 R9 abort does not advance", 16'h0000);
      frame_ref("R9 seq continues", 16'h0000);
   endtask

   task automatic t_off();
      frame_ref("R10 enter shutdown", 16'h80C0);
      frame_ref("R10 shutdown outputs zero", 16'h0000);
      chk("R10 shutdown word", ref_word(), 16'h0000);
      frame_ref("R10 write in shutdown", 16'h8240);
      frame_ref("R10 resumed on ch2", 16'h0000);
   endtask

   initial begin
      samples = {12'h12E, 12'h807, 12'h3F1, 12'hA5C};
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_manual();
      t_no_pipeline();
      t_coding();
      t_range();
      t_abort();
      t_seq();
      t_off();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule